// File: doc/BRIEF.md
# Byte-Lane Sequencer for 8-Bit Bus Sizing

This block sits beside a 32-bit processor that has been told to use an 8-bit data bus. For every access the processor drives active-low byte enables for all the bytes it wants. The bus moves only one byte per cycle. The processor then reissues the cycle with that byte's enable released, and it keeps doing so until no requested byte is left. At each address strobe the block picks the lowest-numbered enabled byte and turns it into the two low address bits. It also drives exactly one active-low output enable, for the transceiver of the matching byte lane.

The address bits and lane enables are registered at the strobe. They are held until ready closes the cycle. Outside a cycle every lane transceiver stays off, so no two lanes can drive the bus at once. When ready closes the cycle that carried the highest requested byte, the block raises a one-clock done pulse. This marks the end of the whole sized transfer.

Top module: `bus8_lane_seq`

## Requirements
- R1: After reset, `addr_lo` is 0, every bit of `lane_oe_n` is 1 and `xfer_done` is 0.
- R2: Bit i of `be_n` requests byte lane i, and a request is active when the bit is 0. The clock edge at which `ads_n` is sampled low starts a cycle if no cycle is active. From the next clock, `addr_lo` holds the index of the lowest-numbered requested lane.
- R3: While a cycle is active, exactly one bit of `lane_oe_n` is 0, and it is bit `addr_lo`.
- R4: While no cycle is active, every bit of `lane_oe_n` is 1.
- R5: From the start of a cycle until ready ends it, `addr_lo` and `lane_oe_n` stay unchanged. Changes on `be_n` and further low samples of `ads_n` during this time have no effect.
- R6: A strobe with no byte requested (`be_n` all ones) starts no cycle. It forces `addr_lo` to 0, keeps all lanes off and produces no done pulse.
- R7: The clock edge at which `rdy_n` is sampled low during an active cycle ends the cycle. The cycle is then inactive from the next clock.
- R8: If the byte of the cycle that ready ends was the highest requested byte at its strobe, `xfer_done` is 1 for exactly the one clock after that edge. Otherwise `xfer_done` stays 0.
- R9: The reissue sequence `be_n` = 0000, 0001, 0011, 0111 gives `addr_lo` = 0, 1, 2, 3. It gives a single done pulse, after the fourth cycle.
- R10: A low `rdy_n` while no cycle is active has no effect and gives no done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| be_n | input | LANES | Byte enables, active low, bit i = lane i |
| ads_n | input | 1 | Address strobe, active low |
| rdy_n | input | 1 | Cycle ready, active low |
| addr_lo | output | $clog2(LANES) | Low address bits of the selected lane |
| lane_oe_n | output | LANES | Lane transceiver enables, active low, one-hot |
| xfer_done | output | 1 | One-clock pulse at the end of a complete sized transfer |

## Verification
The bench builds the block with the default of four lanes and two address bits. This exercises every encoder output from 0 to 3 and every lane enable. With this width, the full four-step reissue sequence can be checked as well as sparse patterns such as lanes 1 and 3 only. It also covers single-lane requests at the top lane, empty strobes, and wait states in which the inputs change in the middle of a cycle.

// File: rtl/bus8_lane_seq.sv
module bus8_lane_seq #(
  parameter int LANES = 4,
  localparam int AW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] be_n,
  input  logic             ads_n,
  input  logic             rdy_n,
  output logic [AW-1:0]    addr_lo,
  output logic [LANES-1:0] lane_oe_n,
  output logic             xfer_done
);

  logic [LANES-1:0] req;
  logic [AW-1:0]    low_idx;
  logic             last_byte;
  logic             cyc_q, last_q, done_q;
  logic [AW-1:0]    addr_q;

  assign req       = ~be_n;
  assign last_byte = (req & (req - LANES'(1))) == '0;

  always_comb begin
    low_idx = '0;
    for (int i = LANES - 1; i >= 0; i--)
      if (req[i]) low_idx = AW'(i);
  end

  wire start = !cyc_q && !ads_n;
  wire finish = cyc_q && !rdy_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= 1'b0;
      last_q <= 1'b0;
      done_q <= 1'b0;
      addr_q <= '0;
    end else begin
      done_q <= finish && last_q;
      if (start) begin
        cyc_q  <= |req;
        addr_q <= low_idx;
        last_q <= last_byte;
      end else if (finish) begin
        cyc_q <= 1'b0;
      end
    end
  end

  assign addr_lo   = addr_q;
  assign xfer_done = done_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_oe_n[g] = !(cyc_q && addr_q == AW'(g));
  end

  // R3
  one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_q |-> $countones(~lane_oe_n) == 1);

  // R4
  idle_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_q |-> &lane_oe_n);

  // R5
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_q && $past(cyc_q) |-> $stable(addr_lo) && $stable(lane_oe_n));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !cyc_q && &lane_oe_n);

endmodule

// File: tb/bus8_lane_seq_tb_top.sv
module bus8_lane_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] be_n = 4'hF;
  logic       ads_n = 1'b1;
  logic       rdy_n = 1'b1;
  logic [1:0] addr_lo;
  logic [3:0] lane_oe_n;
  logic       xfer_done;
  int checks = 0;
  int fails = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  bus8_lane_seq dut_i (.clk(clk), .rst_n(rst_n), .be_n(be_n), .ads_n(ads_n),
    .rdy_n(rdy_n), .addr_lo(addr_lo), .lane_oe_n(lane_oe_n), .xfer_done(xfer_done));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] oe_of(int idx);
    return ~(4'b0001 << idx);
  endfunction

  task automatic run_cycle(logic [3:0] be, int exp_a, bit exp_last, int waits);
    @(negedge clk); be_n = be; ads_n = 1'b0;
    @(negedge clk); ads_n = 1'b1;
    chk("R2 addr", 8'(addr_lo), 8'(exp_a));
    chk("R3 lane", 8'(lane_oe_n), 8'(oe_of(exp_a)));
    for (int w = 0; w < waits; w++) begin
      be_n = ~be; ads_n = 1'b0;
      @(negedge clk);
      chk("R5 addr held", 8'(addr_lo), 8'(exp_a));
      chk("R5 lane held", 8'(lane_oe_n), 8'(oe_of(exp_a)));
    end
    ads_n = 1'b1; be_n = be; rdy_n = 1'b0;
    @(negedge clk); rdy_n = 1'b1;
    chk("R7 lanes off", 8'(lane_oe_n), 8'hF);
    chk("R8 done", 8'(xfer_done), 8'(exp_last));
    @(negedge clk);
    chk("R8 done one clock", 8'(xfer_done), 8'h0);
  endtask

  task automatic t_reset();
    chk("R1 addr", 8'(addr_lo), 8'h0);
    chk("R1 lanes", 8'(lane_oe_n), 8'hF);
    chk("R1 done", 8'(xfer_done), 8'h0);
  endtask

  task automatic t_sequence();
    run_cycle(4'b0000, 0, 0, 0);
    run_cycle(4'b0001, 1, 0, 1);
    run_cycle(4'b0011, 2, 0, 0);
    run_cycle(4'b0111, 3, 1, 2); // R9
  endtask

  task automatic t_sparse();
    run_cycle(4'b0101, 1, 0, 0);
    run_cycle(4'b0111, 3, 1, 0);
    run_cycle(4'b1011, 2, 1, 1);
    run_cycle(4'b1110, 0, 1, 0);
  endtask

  task automatic t_empty();
    run_cycle(4'b1011, 2, 1, 0);
    @(negedge clk); be_n = 4'hF; ads_n = 1'b0;
    @(negedge clk); ads_n = 1'b1;
    chk("R6 addr zero", 8'(addr_lo), 8'h0);
    chk("R6 lanes off", 8'(lane_oe_n), 8'hF);
    rdy_n = 1'b0;
    @(negedge clk); rdy_n = 1'b1;
    chk("R6 no done", 8'(xfer_done), 8'h0);
  endtask

  task automatic t_stray_ready();
    @(negedge clk); rdy_n = 1'b0;
    @(negedge clk);
    chk("R10 no done", 8'(xfer_done), 8'h0);
    chk("R10 lanes off", 8'(lane_oe_n), 8'hF);
    @(negedge clk); rdy_n = 1'b1;
    chk("R10 still no done", 8'(xfer_done), 8'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_sequence();
    t_sparse();
    t_empty();
    t_stray_ready();
    ended = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule